// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital controller wrapped around a successive-approximation converter. Software sees four byte-wide registers: a selection register (input channel and gain code, reference choice, result alignment), a control register (enable, start, free-run, completion flag, interrupt enable, clock divider code), and two data bytes that together carry a 10-bit result. The block divides the system clock into a conversion clock and counts conversion-clock ticks. It hands the analog core a channel and reference that stay fixed for the whole conversion, captures the core's result at the last tick and raises a completion interrupt.

A conversion takes 13 conversion-clock ticks. The first conversion after the enable bit is set takes 25 ticks, because it also initialises the analog core. In free-running mode a single start keeps conversions going back to back until software clears the free-run bit. Reading the low data byte captures the high byte, so that a two-byte read of one result stays consistent even if a new result lands between the two reads.

The sequencer is built around one state machine with three states. The states are `ST_IDLE` (no conversion), `ST_INIT` (extended first conversion) and `ST_RUN` (normal conversion). It has these transitions:
- IDLE→INIT: a start is written and no initialisation has run since the last enable.
- IDLE→RUN: a start is written and initialisation has already run.
- INIT→RUN and RUN→RUN: the last tick of a conversion arrives with free-run set.
- INIT→IDLE and RUN→IDLE: the last tick arrives with free-run clear.
- any→IDLE (abort): software writes the enable bit to 0.

Top module: `adc_seq_top`

## Requirements
- R1: Registers sit at four addresses: 0 = selection (bits 7:3 channel, bits 2:1 reference, bit 0 left-align), 1 = control (bits 7:5 divider code, bit 4 interrupt enable, bit 3 completion flag, bit 2 free-run, bit 1 start, bit 0 enable), 2 = low data byte, 3 = high data byte. After reset every register reads 0 and `irq` is 0.
- R2: A control write with enable=1 and start=1 launches a conversion when the block is idle. A control write with start=0 launches nothing. The start bit reads 1 while a conversion runs and 0 once it has finished.
- R3: A normal conversion lasts 13 conversion-clock ticks. The completion flag is visible exactly 13×divisor system cycles after the clock edge that took the start write.
- R4: The first launch after the enable bit was last 0 runs an extended conversion of 25 ticks, with `core_init` high, and produces one result. This includes a start written in the same write as the enable.
- R5: Divider codes 0 to 7 divide the system clock by 2, 2, 4, 8, 16, 32, 64 and 128.
- R6: `core_chan` and `core_ref` are loaded from the selection register only when a conversion begins. A selection write during a conversion affects only the next conversion, and each result belongs to the values loaded at its start.
- R7: With left-align 0 the low byte is result[7:0] and the high byte is {6'b0, result[9:8]}. With left-align 1 the low byte is {result[1:0], 6'b0} and the high byte is result[9:2]. Changing the bit changes the data view at once, even during a conversion.
- R8: In free-running mode a single start gives back-to-back conversions with no idle cycle between them. Clearing free-run lets the current conversion finish and then stops.
- R9: Writing enable=0 during a conversion aborts it. No result is stored and the flag does not change. The start bit reads 0 on the next cycle, and the next launch is extended.
- R10: The completion flag sets when the data bytes are updated. It clears when a control write has bit 3 at 1, or when `irq_ack` pulses. A write with bit 3 at 0 leaves it unchanged.
- R11: `irq` is high exactly when the completion flag, the interrupt enable bit and `glb_irq_en` are all 1.
- R12: Reading the low byte captures the result for the high byte. The next high-byte read returns the captured value even if a newer result has arrived, and that read releases the capture.
- R13: `core_sample` pulses for one cycle in the first cycle of every conversion. `core_tick` pulses only while a conversion runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (has side effects on the data bytes) |
| reg_addr | input | 2 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `reg_addr` (combinational) |
| glb_irq_en | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge; clears the completion flag |
| irq | output | 1 | Completion interrupt request |
| core_sample | output | 1 | One-cycle pulse: analog core starts a conversion |
| core_init | output | 1 | High during an extended initialising conversion |
| core_chan | output | 5 | Channel/gain code held for the running conversion |
| core_ref | output | 2 | Reference code held for the running conversion |
| core_tick | output | 1 | Conversion-clock tick to the analog core |
| core_result | input | 10 | Result from the analog core, captured at the last tick |

## Verification
The hardest situation to reach is a result landing between the two halves of a split data read. That needs a low-byte read, then a complete new conversion on a different channel, and only then the high-byte read. The bench reaches it by reading only the low byte and running a second conversion whose high bits differ. It then reads the high byte and the low byte in turn, so it sees the stale captured high byte next to the fresh live low byte.

Free-running spacing is also awkward to see. After the first completion, the bench clears the flag while the chain keeps going and measures the cycles to the next flag from that write. The expected count follows from the relaunch happening on the completion edge itself.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int RES_W  = 10;
    localparam int CHAN_W = 5;
    localparam int REF_W  = 2;
    localparam int PS_W   = 3;
    localparam int VIEW_W = 2 * DATA_W;

    localparam logic [ADDR_W-1:0] A_SEL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;
    localparam logic [ADDR_W-1:0] A_LO   = 2'd2;
    localparam logic [ADDR_W-1:0] A_HI   = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_INIT = 2'd1,
        ST_RUN  = 2'd2
    } conv_state_e;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [REF_W-1:0]  refsel;
        logic              left;
    } sel_reg_t;

    typedef struct packed {
        logic [PS_W-1:0] prescale;
        logic            irq_en;
        logic            flag;
        logic            free_run;
        logic            start;
        logic            enable;
    } ctrl_reg_t;

    // 16-bit view of a result: right aligned, or pushed to the top.
    function automatic logic [VIEW_W-1:0] place(input logic [RES_W-1:0] r,
                                                input logic left);
        logic [VIEW_W-1:0] v;
        v = VIEW_W'(r);
        if (left)
            v = v << (VIEW_W - RES_W);
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] view_lo(input logic [RES_W-1:0] r,
                                                  input logic left);
        logic [VIEW_W-1:0] v;
        v = place(r, left);
        return v[DATA_W-1:0];
    endfunction

    function automatic logic [DATA_W-1:0] view_hi(input logic [RES_W-1:0] r,
                                                  input logic left);
        logic [VIEW_W-1:0] v;
        v = place(r, left);
        return v[VIEW_W-1:DATA_W];
    endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PS_W-1:0] prescale,
    output logic            tick
);

    localparam int MAX_SHIFT = (1 << PS_W) - 1;
    localparam int CNT_W     = MAX_SHIFT;

    logic [PS_W-1:0]  shamt;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_q;

    // Code 0 divides by 2 like code 1; code k divides by 2**k otherwise.
    always_comb begin
        shamt = (prescale == '0) ? PS_W'(1) : prescale;
        span  = (CNT_W+1)'(1) << shamt;
        limit = CNT_W'(span - 1'b1);
    end

    // The counter rests at zero while idle, so a launch starts a full period.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || (cnt_q == limit))
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == limit);

endmodule

// File: rtl/adc_conv_fsm.sv
module adc_conv_fsm import adc_seq_pkg::*; #(
    parameter int NORM_TICKS = 13,
    parameter int INIT_TICKS = 25,
    parameter int CH_W       = 5,
    parameter int RF_W       = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            launch_req,
    input  logic            abort_req,
    input  logic            free_run,
    input  logic            tick,
    input  logic [CH_W-1:0] sel_chan,
    input  logic [RF_W-1:0] sel_ref,
    output logic            busy,
    output logic            running_init,
    output logic            complete,
    output logic            core_sample,
    output logic [CH_W-1:0] core_chan,
    output logic [RF_W-1:0] core_ref
);

    localparam int MAXT   = (INIT_TICKS > NORM_TICKS) ? INIT_TICKS : NORM_TICKS;
    localparam int TCNT_W = $clog2(MAXT);

    conv_state_e       state_q, state_d;
    logic [TCNT_W-1:0] tcnt_q, tcnt_d;
    logic [TCNT_W-1:0] last_tick;
    logic              init_done_q;
    logic              sample_go;
    logic              sample_q;
    logic [CH_W-1:0]   chan_q;
    logic [RF_W-1:0]   ref_q;

    assign last_tick = (state_q == ST_INIT) ? TCNT_W'(INIT_TICKS - 1)
                                            : TCNT_W'(NORM_TICKS - 1);

    // Next state, tick count and event strobes.
    always_comb begin
        state_d   = state_q;
        tcnt_d    = tcnt_q;
        complete  = 1'b0;
        sample_go = 1'b0;
        if (abort_req) begin
            state_d = ST_IDLE;
            tcnt_d  = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (launch_req) begin
                        sample_go = 1'b1;
                        tcnt_d    = '0;
                        state_d   = init_done_q ? ST_RUN : ST_INIT;
                    end
                end
                ST_INIT, ST_RUN: begin
                    if (tick) begin
                        if (tcnt_q == last_tick) begin
                            complete = 1'b1;
                            tcnt_d   = '0;
                            if (free_run) begin
                                state_d   = ST_RUN;
                                sample_go = 1'b1;
                            end else begin
                                state_d = ST_IDLE;
                            end
                        end else begin
                            tcnt_d = tcnt_q + 1'b1;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            tcnt_q  <= tcnt_d;
        end
    end

    // Output registers: held selection, sample pulse, initialisation memory.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_q    <= 1'b0;
            chan_q      <= '0;
            ref_q       <= '0;
            init_done_q <= 1'b0;
        end else begin
            sample_q <= sample_go;
            if (sample_go) begin
                chan_q <= sel_chan;
                ref_q  <= sel_ref;
            end
            if (abort_req)
                init_done_q <= 1'b0;
            else if (complete)
                init_done_q <= 1'b1;
        end
    end

    assign busy         = (state_q != ST_IDLE);
    assign running_init = (state_q == ST_INIT);
    assign core_sample  = sample_q;
    assign core_chan    = chan_q;
    assign core_ref     = ref_q;

endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs import adc_seq_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              complete,
    input  logic [RES_W-1:0]  core_result,
    input  logic              left,
    input  logic              rd_lo,
    input  logic              rd_hi,
    output logic [DATA_W-1:0] lo_byte,
    output logic [DATA_W-1:0] hi_byte
);

    logic [RES_W-1:0] res_q;
    logic [RES_W-1:0] hold_q;
    logic             lock_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            res_q <= '0;
        else if (complete)
            res_q <= core_result;
    end

    // A low-byte read captures the result for the matching high-byte read.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            lock_q <= 1'b0;
        end else if (rd_lo) begin
            hold_q <= res_q;
            lock_q <= 1'b1;
        end else if (rd_hi) begin
            lock_q <= 1'b0;
        end
    end

    // Alignment is applied on the read path, so it acts at once.
    assign lo_byte = view_lo(res_q, left);
    assign hi_byte = lock_q ? view_hi(hold_q, left) : view_hi(res_q, left);

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top import adc_seq_pkg::*; #(
    parameter int NORM_TICKS = 13,
    parameter int INIT_TICKS = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              glb_irq_en,
    input  logic              irq_ack,
    output logic              irq,
    output logic              core_sample,
    output logic              core_init,
    output logic [CHAN_W-1:0] core_chan,
    output logic [REF_W-1:0]  core_ref,
    output logic              core_tick,
    input  logic [RES_W-1:0]  core_result
);

    sel_reg_t          sel_q;
    ctrl_reg_t         cw;
    logic              en_q, fr_q, ie_q, flag_q;
    logic [PS_W-1:0]   ps_q;
    logic              wr_sel, wr_ctrl;
    logic              launch_req, abort_req;
    logic              conv_busy, conv_done;
    logic              rd_lo, rd_hi;
    logic [DATA_W-1:0] lo_byte, hi_byte;

    assign cw         = ctrl_reg_t'(wr_data);
    assign wr_sel     = wr_en && (reg_addr == A_SEL);
    assign wr_ctrl    = wr_en && (reg_addr == A_CTRL);
    assign launch_req = wr_ctrl && cw.enable && cw.start;
    assign abort_req  = wr_ctrl && !cw.enable;
    assign rd_lo      = rd_en && (reg_addr == A_LO);
    assign rd_hi      = rd_en && (reg_addr == A_HI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            en_q  <= 1'b0;
            fr_q  <= 1'b0;
            ie_q  <= 1'b0;
            ps_q  <= '0;
        end else begin
            if (wr_sel)
                sel_q <= sel_reg_t'(wr_data);
            if (wr_ctrl) begin
                en_q <= cw.enable;
                fr_q <= cw.free_run;
                ie_q <= cw.irq_en;
                ps_q <= cw.prescale;
            end
        end
    end

    // Completion flag: a new result wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (conv_done)
            flag_q <= 1'b1;
        else if ((wr_ctrl && cw.flag) || irq_ack)
            flag_q <= 1'b0;
    end

    adc_clk_div #(
        .PS_W (PS_W)
    ) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (conv_busy),
        .prescale (ps_q),
        .tick     (core_tick)
    );

    adc_conv_fsm #(
        .NORM_TICKS (NORM_TICKS),
        .INIT_TICKS (INIT_TICKS),
        .CH_W       (CHAN_W),
        .RF_W       (REF_W)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch_req   (launch_req),
        .abort_req    (abort_req),
        .free_run     (fr_q),
        .tick         (core_tick),
        .sel_chan     (sel_q.chan),
        .sel_ref      (sel_q.refsel),
        .busy         (conv_busy),
        .running_init (core_init),
        .complete     (conv_done),
        .core_sample  (core_sample),
        .core_chan    (core_chan),
        .core_ref     (core_ref)
    );

    adc_result_regs res_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .complete    (conv_done),
        .core_result (core_result),
        .left        (sel_q.left),
        .rd_lo       (rd_lo),
        .rd_hi       (rd_hi),
        .lo_byte     (lo_byte),
        .hi_byte     (hi_byte)
    );

    always_comb begin
        rd_data = '0;
        case (reg_addr)
            A_SEL:   rd_data = sel_q;
            A_CTRL:  rd_data = {ps_q, ie_q, flag_q, fr_q, conv_busy, en_q};
            A_LO:    rd_data = lo_byte;
            A_HI:    rd_data = hi_byte;
            default: rd_data = '0;
        endcase
    end

    assign irq = flag_q && ie_q && glb_irq_en;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk import adc_seq_pkg::*; (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              busy,
    input logic              flag,
    input logic              irq,
    input logic              glb_irq_en,
    input logic              core_sample,
    input logic              core_tick,
    input logic [CHAN_W-1:0] core_chan
);

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && glb_irq_en));

    // R9
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !busy);

    // R13
    sample_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_sample |-> busy);

    // R13
    tick_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_tick |-> busy);

    // R6
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !core_sample) |-> $stable(core_chan));

    // R10
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(busy));

endmodule

bind adc_seq_top adc_seq_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en_q),
    .busy        (conv_busy),
    .flag        (flag_q),
    .irq         (irq),
    .glb_irq_en  (glb_irq_en),
    .core_sample (core_sample),
    .core_tick   (core_tick),
    .core_chan   (core_chan)
);

// File: tb/adc_seq_top_tb_top.sv
module adc_seq_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] A_SEL = 2'd0, A_CTRL = 2'd1, A_LO = 2'd2, A_HI = 2'd3;
    localparam logic [7:0] C_IDLE = 8'h11, C_GO = 8'h13, C_CLR = 8'h19;
    localparam logic [7:0] C_FR_GO = 8'h17, C_FR_CLR = 8'h1D;

    // {fresh, divider code, channel, reference, left-align}
    localparam logic [11:0] VEC [8] = '{
        {1'b1, 3'd0, 5'd1,  2'd0, 1'b0},
        {1'b0, 3'd1, 5'd7,  2'd1, 1'b1},
        {1'b0, 3'd2, 5'd31, 2'd3, 1'b0},
        {1'b0, 3'd3, 5'd16, 2'd2, 1'b1},
        {1'b0, 3'd4, 5'd10, 2'd1, 1'b0},
        {1'b1, 3'd5, 5'd21, 2'd0, 1'b1},
        {1'b0, 3'd6, 5'd2,  2'd3, 1'b0},
        {1'b0, 3'd7, 5'd27, 2'd2, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       glb_irq_en = 1'b0, irq_ack = 1'b0;
    logic       irq, core_sample, core_init, core_tick;
    logic [4:0] core_chan;
    logic [1:0] core_ref;
    logic [9:0] core_result;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Analog core stand-in: result encodes the held channel and reference.
    assign core_result = {core_chan, core_ref, 3'b101};

    adc_seq_top dut_i (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
        .reg_addr (reg_addr), .wr_data (wr_data), .rd_data (rd_data),
        .glb_irq_en (glb_irq_en), .irq_ack (irq_ack), .irq (irq),
        .core_sample (core_sample), .core_init (core_init),
        .core_chan (core_chan), .core_ref (core_ref),
        .core_tick (core_tick), .core_result (core_result)
    );

    function automatic logic [9:0] res_of(input logic [4:0] c, input logic [1:0] r);
        return {c, r, 3'b101};
    endfunction
    function automatic logic [7:0] lo_of(input logic [9:0] r, input logic left);
        return left ? {r[1:0], 6'b0} : r[7:0];
    endfunction
    function automatic logic [7:0] hi_of(input logic [9:0] r, input logic left);
        return left ? r[9:2] : {6'b0, r[9:8]};
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; reg_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (!irq && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_data(input string req, input logic [9:0] r, input logic left);
        logic [7:0] v;
        rd(A_LO, v);
        check(req, "low byte", v, lo_of(r, left));
        rd(A_HI, v);
        check(req, "high byte", v, hi_of(r, left));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_SEL, v);  check("R1", "selection after reset", v, 0);
        rd(A_CTRL, v); check("R1", "control after reset", v, 0);
        rd(A_LO, v);   check("R1", "low byte after reset", v, 0);
        rd(A_HI, v);   check("R1", "high byte after reset", v, 0);
        check("R1", "irq after reset", irq, 0);
        glb_irq_en = 1'b1;

        // Table walk: timing per divider code, extended starts, alignment.
        for (int i = 0; i < 8; i++) begin
            logic [11:0] t;
            logic        fresh, al;
            logic [2:0]  ps;
            logic [4:0]  ch;
            logic [1:0]  rf;
            int          div;
            t = VEC[i];
            fresh = t[11]; ps = t[10:8]; ch = t[7:3]; rf = t[2:1]; al = t[0];
            div = (ps == 0) ? 2 : (1 << ps);
            if (fresh) wr(A_CTRL, 8'h00);
            wr(A_SEL, {ch, rf, al});
            wr(A_CTRL, {ps, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1});
            check("R13", "sample pulse at launch", core_sample, 1);
            check("R4", "init marker at launch", core_init, fresh);
            wait_irq(n);
            check("R3_R5", "cycles to flag", n, (fresh ? 25 : 13) * div);
            rd(A_CTRL, v);
            check("R2", "start bit after finish", v[1], 0);
            check_data("R7", res_of(ch, rf), al);
            wr(A_CTRL, {ps, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1});
            check("R10", "irq after W1C", irq, 0);
        end

        // R2: start written 0 does nothing
        wr(A_CTRL, C_IDLE);
        repeat (40) @(negedge clk);
        check("R2", "irq with no start", irq, 0);
        rd(A_CTRL, v);
        check("R2", "start bit stays 0", v[1], 0);

        // R6: selection written mid-conversion waits for the next one
        wr(A_SEL, {5'd3, 2'd1, 1'b0});
        wr(A_CTRL, C_GO);
        rd(A_CTRL, v);
        check("R2", "start bit while busy", v[1], 1);
        wr(A_SEL, {5'd9, 2'd2, 1'b0});
        check("R6", "held channel", core_chan, 3);
        check("R6", "held reference", core_ref, 1);
        wait_irq(n);
        check_data("R6", res_of(5'd3, 2'd1), 1'b0);
        wr(A_CTRL, C_CLR);
        wr(A_CTRL, C_GO);
        wait_irq(n);
        check_data("R6", res_of(5'd9, 2'd2), 1'b0);

        // R7: alignment acts at once, also during a conversion
        wr(A_SEL, {5'd9, 2'd2, 1'b1});
        check_data("R7", res_of(5'd9, 2'd2), 1'b1);
        wr(A_CTRL, C_CLR);
        wr(A_CTRL, C_GO);
        wr(A_SEL, {5'd9, 2'd2, 1'b0});
        rd(A_HI, v);
        check("R7", "high byte realigned while busy", v, hi_of(res_of(5'd9, 2'd2), 1'b0));
        wait_irq(n);
        wr(A_CTRL, C_CLR);

        // R9: abort by clearing enable
        wr(A_SEL, {5'd14, 2'd3, 1'b0});
        wr(A_CTRL, C_GO);
        repeat (5) @(negedge clk);
        wr(A_CTRL, 8'h10);
        rd(A_CTRL, v);
        check("R9", "start bit after abort", v[1], 0);
        repeat (60) @(negedge clk);
        check("R9", "no flag after abort", irq, 0);
        check_data("R9", res_of(5'd9, 2'd2), 1'b0);
        wr(A_CTRL, C_GO);
        check("R4", "init marker after re-enable", core_init, 1);
        wait_irq(n);
        check("R4", "extended cycles after abort", n, 50);
        check_data("R9", res_of(5'd14, 2'd3), 1'b0);
        wr(A_CTRL, C_CLR);

        // R8: free-running chain and its stop
        wr(A_CTRL, C_FR_GO);
        wait_irq(n);
        check("R8", "first free-run period", n, 26);
        wr(A_CTRL, C_FR_CLR);
        wait_irq(n);
        check("R8", "chained period", n, 24);
        wr(A_CTRL, C_CLR);
        wait_irq(n);
        check("R8", "last conversion after free-run off", n, 24);
        wr(A_CTRL, C_CLR);
        repeat (60) @(negedge clk);
        check("R8", "no flag after chain stops", irq, 0);
        rd(A_CTRL, v);
        check("R8", "idle after chain stops", v[1], 0);

        // R11 gating and R10 acknowledge
        wr(A_CTRL, C_GO);
        wait_irq(n);
        check("R11", "irq with all enables", irq, 1);
        glb_irq_en = 1'b0;
        #1 check("R11", "irq with global off", irq, 0);
        glb_irq_en = 1'b1;
        #1 check("R11", "irq with global back on", irq, 1);
        wr(A_CTRL, 8'h01);
        check("R11", "irq with local enable off", irq, 0);
        rd(A_CTRL, v);
        check("R10", "flag kept by write of 0", v[3], 1);
        wr(A_CTRL, C_IDLE);
        check("R11", "irq with local enable on", irq, 1);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        check("R10", "irq after acknowledge", irq, 0);
        rd(A_CTRL, v);
        check("R10", "flag after acknowledge", v[3], 0);

        // R12: split read across a newer result
        wr(A_SEL, {5'd20, 2'd0, 1'b0});
        wr(A_CTRL, C_GO);
        wait_irq(n);
        wr(A_CTRL, C_CLR);
        rd(A_LO, v);
        check("R12", "low byte first result", v, lo_of(res_of(5'd20, 2'd0), 1'b0));
        wr(A_SEL, {5'd5, 2'd3, 1'b0});
        wr(A_CTRL, C_GO);
        wait_irq(n);
        wr(A_CTRL, C_CLR);
        rd(A_HI, v);
        check("R12", "high byte stays captured", v, hi_of(res_of(5'd20, 2'd0), 1'b0));
        check_data("R12", res_of(5'd5, 2'd3), 1'b0);

        summary();
    end

endmodule